// File: doc/BRIEF.md
# Audio Transmit FIFO with Sample Packing

This block is the transmit side of a single audio channel. Software reaches it through a small word-addressed register port. It first programs a control word that sets the enable, the active frame slots, the sample width and the packed (compact) mode. It then writes sample words. Each sample is left-justified into a 20-bit container and stored in a circular FIFO. In compact mode, one write carries two 16-bit halves.

Once the FIFO is at least half full, and the channel is enabled with slot 3 or slot 4 active, the block offers (left, right) pairs to a downstream sink over a valid/ready handshake. It keeps offering pairs until fewer than two entries remain. The block keeps sticky status flags and a raw interrupt vector. An interrupt enable mask combines them into a single interrupt line.

Top module: `audio_tx_fifo`

## Requirements
- R1: Register word addresses are 0 control, 1 sample data, 2 status, 3 raw interrupts, 4 interrupt enable, 5 interrupt clear, 6 main control and 7 identification. In the control word, bit 0 enables the channel, bits 12:1 are slot enables (bit 3 is slot 3, bit 4 is slot 4), bits 14:13 give the sample size (0=16, 1=18, 2=20, 3=12 bits) and bit 15 requests compact mode. The control and interrupt enable registers read back what was written.
- R2: Compact mode takes effect only for 12-bit and 16-bit sizes. With an 18-bit or 20-bit size, a compact request is ignored and each write stores one sample.
- R3: In non-compact mode, a data write stores one entry: write bits 19:0 shifted left by 8, 4, 2 or 0 for 12, 16, 18 or 20 bits, truncated to 20 bits. The write is accepted only while the level is below DEPTH; otherwise it is dropped. The level never exceeds DEPTH.
- R4: In compact mode, a data write stores two entries, bits 15:0 first and then bits 31:16. Each half is shifted left by 8 (12-bit) or 4 (16-bit) and truncated to 20 bits. The write is accepted only when the level plus 2 is strictly below DEPTH; otherwise both halves are dropped.
- R5: The status word has bit 0 empty, bit 1 half-empty, bit 2 full, bit 3 underrun, bit 4 busy (a pair is being offered) and the level in bits 27:16. An accepted push clears empty and underrun when the new level is non-zero, clears half-empty when the new level is at least DEPTH/2, and sets full when the new level reaches DEPTH.
- R6: A pair is offered only when control bit 0 is set and slot 3 or slot 4 is enabled. Offering starts at a level of at least DEPTH/2 and continues while two or more entries remain. snk_data carries the older entry (left) in bits 39:20 and the next entry (right) in bits 19:0. A pair is removed only in a cycle with snk_valid and snk_ready both high. A refused pair stays offered.
- R7: After a pop, full is cleared, half-empty is set when the new level is at most DEPTH/2, and empty and underrun are both set when the new level is 0.
- R8: The raw interrupt bits are bit 5 (underrun flag), bit 2 (half-empty flag) and bit 0 (empty and not busy). irq is high when any raw bit meets a set bit in the enable register.
- R9: A write to the interrupt-clear register with bit 5 set clears the underrun flag. Other bits of that register have no effect.
- R10: Writing main control with bit 0 clear empties the FIFO, leaves empty and half-empty set, and clears full and underrun.
- R11: DEPTH must be 8, 32, 64, 128, 256, 512, 1024 or 2048; any other value, 16 included, stops elaboration. The identification register reports the depth as code 0 to 7 in that order.
- R12: After reset, the status word reads 0x3, the raw interrupts read 0x05, the control word reads 0, irq is low and snk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| snk_valid | output | 1 | A left/right pair is offered |
| snk_ready | input | 1 | Sink accepts the offered pair |
| snk_data | output | 40 | Left sample in 39:20, right sample in 19:0 |
| irq | output | 1 | Masked interrupt |

## Verification
Most faults inside the block reach the ports quickly. A pointer that slips, or an entry stored in the wrong lane, first shows up as a wrong left/right value the next time a pair is offered, which can be several writes after the fault. A wrong acceptance decision shows in the status level field in the cycle after the offending data write. A sticky flag that is set or cleared wrongly changes the status word, the raw interrupt vector and, through the mask, irq, all one clock after the push, pop or register write that caused it. A drain gate or burst tracker that is wrong shows as snk_valid asserted below the half-full mark, or dropped while pairs are still waiting.

// File: rtl/atx_pkg.sv
// Package: shared constants, flag type and helper functions for the
// audio transmit FIFO. Assumes 20-bit sample containers throughout.
package atx_pkg;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_DATA = 3'd1,
        A_STAT = 3'd2,
        A_RIS  = 3'd3,
        A_IE   = 3'd4,
        A_ICLR = 3'd5,
        A_MAIN = 3'd6,
        A_ID   = 3'd7
    } atx_addr_e;

    localparam int SAMPLE_W  = 20;
    localparam int CTL_EN    = 0;
    localparam int CTL_SLOT3 = 3;
    localparam int CTL_SLOT4 = 4;
    localparam int CTL_SZ_LO = 13;
    localparam int CTL_CMP   = 15;
    localparam int RIS_DONE  = 0;
    localparam int RIS_TX    = 2;
    localparam int RIS_UR    = 5;
    localparam int ICLR_UR   = 5;

    localparam logic [1:0] SZ_16 = 2'd0;
    localparam logic [1:0] SZ_18 = 2'd1;
    localparam logic [1:0] SZ_20 = 2'd2;
    localparam logic [1:0] SZ_12 = 2'd3;

    typedef struct packed {
        logic underrun;
        logic full;
        logic half_empty;
        logic empty;
    } atx_flags_t;

    // Left-justify a raw sample into the 20-bit container by its width.
    function automatic logic [SAMPLE_W-1:0] pad20(input logic [SAMPLE_W-1:0] raw,
                                                  input logic [1:0] sz);
        case (sz)
            SZ_16:   return raw << 4;
            SZ_18:   return raw << 2;
            SZ_20:   return raw;
            default: return raw << 8;
        endcase
    endfunction

    // Depth encoded by index: 0 -> 8, i -> 16 << i for i in 1..7.
    function automatic int depth_of(input int code);
        return (code == 0) ? 8 : (16 << code);
    endfunction

    function automatic bit depth_ok(input int d);
        for (int i = 0; i < 8; i++) begin
            if (d == depth_of(i)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [2:0] depth_code(input int d);
        for (int i = 0; i < 8; i++) begin
            if (d == depth_of(i)) return 3'(i);
        end
        return 3'd0;
    endfunction

endpackage

// File: rtl/atx_sample_pack.sv
// Sample packer: turns one data-register write into one or two 20-bit
// entries. Assumes the caller has already resolved whether compact
// mode is in effect for the current size.
module atx_sample_pack
    import atx_pkg::*;
(
    input  logic [31:0]         wdata,
    input  logic [1:0]          sz,
    input  logic                compact,
    output logic [SAMPLE_W-1:0] lane0,
    output logic [SAMPLE_W-1:0] lane1
);

    logic [SAMPLE_W-1:0] raw [2];

    // Raw lane selection: compact splits halves, otherwise low 20 bits.
    always_comb begin
        if (compact) begin
            raw[0] = {4'b0, wdata[15:0]};
            raw[1] = {4'b0, wdata[31:16]};
        end else begin
            raw[0] = wdata[SAMPLE_W-1:0];
            raw[1] = '0;
        end
    end

    logic [SAMPLE_W-1:0] padded [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        // Per-lane left justification by sample width.
        always_comb padded[g] = pad20(raw[g], sz);
    end

    assign lane0 = padded[0];
    assign lane1 = padded[1];

endmodule

// File: rtl/atx_ring.sv
// Circular sample store: up to two writes and a two-entry read per
// cycle, no data movement on pop. Assumes the caller only asserts
// push_ok when space exists and pop only when two entries are held.
module atx_ring
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                push_ok,
    input  logic                push_two,
    input  logic [SAMPLE_W-1:0] in0,
    input  logic [SAMPLE_W-1:0] in1,
    input  logic                pop,
    output logic [LW-1:0]       level,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [LW-1:0] wp_q, rp_q;
    logic [AW-1:0] widx0, widx1, ridx0, ridx1;

    assign widx0 = wp_q[AW-1:0];
    assign widx1 = wp_q[AW-1:0] + AW'(1);
    assign ridx0 = rp_q[AW-1:0];
    assign ridx1 = rp_q[AW-1:0] + AW'(1);

    // Entry storage: one or two consecutive slots per accepted push.
    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[widx0] <= in0;
            if (push_two) mem[widx1] <= in1;
        end
    end

    // Pointer update: write advances by push size, read by a pair.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + (push_two ? LW'(2) : LW'(1));
            if (pop)     rp_q <= rp_q + LW'(2);
        end
    end

    assign level     = wp_q - rp_q;
    assign out_left  = mem[ridx0];
    assign out_right = mem[ridx1];

endmodule

// File: rtl/atx_status.sv
// Sticky status flags and raw interrupt vector. Flags change only on
// push, pop, flush or an underrun clear; level_n is the level after
// this cycle's push and pop.
module atx_status
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH) + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_ok,
    input  logic          pop,
    input  logic          iclr_ur,
    input  logic [LW-1:0] level_n,
    input  logic          busy,
    input  logic [6:0]    ie,
    output atx_flags_t    flags,
    output logic [6:0]    ris,
    output logic          irq
);

    atx_flags_t f_q;

    // Flag update: clear request, then push rules, then pop rules.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            f_q <= '{underrun: 1'b0, full: 1'b0, half_empty: 1'b1, empty: 1'b1};
        end else begin
            if (iclr_ur) f_q.underrun <= 1'b0;
            if (push_ok) begin
                if (level_n != '0) begin
                    f_q.empty    <= 1'b0;
                    f_q.underrun <= 1'b0;
                end
                if (int'(level_n) >= HALF)  f_q.half_empty <= 1'b0;
                if (int'(level_n) >= DEPTH) f_q.full       <= 1'b1;
            end
            if (pop) begin
                f_q.full <= 1'b0;
                if (int'(level_n) <= HALF) f_q.half_empty <= 1'b1;
                if (level_n == '0) begin
                    f_q.empty    <= 1'b1;
                    f_q.underrun <= 1'b1;
                end
            end
        end
    end

    // Raw interrupt vector from the flags and the busy indication.
    always_comb begin
        ris           = '0;
        ris[RIS_UR]   = f_q.underrun;
        ris[RIS_TX]   = f_q.half_empty;
        ris[RIS_DONE] = f_q.empty && !busy;
    end

    assign flags = f_q;
    assign irq   = |(ris & ie);

endmodule

// File: rtl/audio_tx_fifo.sv
// Top: register decode, acceptance checks, drain gating and read-back
// for one audio transmit channel. Assumes a single-cycle register
// write strobe and a sink that may hold ready low indefinitely.
module audio_tx_fifo
    import atx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1,
    localparam int HALF = DEPTH / 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        snk_valid,
    input  logic        snk_ready,
    output logic [39:0] snk_data,
    output logic        irq
);

    if (!depth_ok(DEPTH)) begin : g_bad_depth
        initial $fatal(1, "audio_tx_fifo: DEPTH %0d is not supported", DEPTH);
    end

    localparam logic [2:0] DEPTH_CODE = depth_code(DEPTH);

    logic [15:0] ctrl_q;
    logic [6:0]  ie_q;
    logic        main_q;
    logic        burst_q;

    atx_addr_e   addr_e;
    logic        wr_ctrl, data_wr, wr_ie, wr_iclr, wr_main;
    logic        main_flush, iclr_ur;
    logic [1:0]  sz;
    logic        cmp_eff, push_two, push_ok, gate, pop;
    logic [LW-1:0] level, level_n;
    logic [SAMPLE_W-1:0] lane0, lane1, left_s, right_s;
    atx_flags_t  flags;
    logic [6:0]  ris;

    assign addr_e     = atx_addr_e'(reg_addr);
    assign wr_ctrl    = reg_wr && (addr_e == A_CTRL);
    assign data_wr    = reg_wr && (addr_e == A_DATA);
    assign wr_ie      = reg_wr && (addr_e == A_IE);
    assign wr_iclr    = reg_wr && (addr_e == A_ICLR);
    assign wr_main    = reg_wr && (addr_e == A_MAIN);
    assign main_flush = wr_main && !reg_wdata[0];
    assign iclr_ur    = wr_iclr && reg_wdata[ICLR_UR];

    // Control, interrupt enable and main control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ie_q   <= '0;
            main_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata[15:0];
            if (wr_ie)   ie_q   <= reg_wdata[6:0];
            if (wr_main) main_q <= reg_wdata[0];
        end
    end

    assign sz       = ctrl_q[CTL_SZ_LO +: 2];
    assign cmp_eff  = ctrl_q[CTL_CMP] && (sz == SZ_16 || sz == SZ_12);
    assign push_two = cmp_eff;
    assign push_ok  = data_wr && (push_two ? (int'(level) + 2 < DEPTH)
                                           : (int'(level) < DEPTH));

    atx_sample_pack u_pack (
        .wdata   (reg_wdata),
        .sz      (sz),
        .compact (cmp_eff),
        .lane0   (lane0),
        .lane1   (lane1)
    );

    atx_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (main_flush),
        .push_ok   (push_ok),
        .push_two  (push_two),
        .in0       (lane0),
        .in1       (lane1),
        .pop       (pop),
        .level     (level),
        .out_left  (left_s),
        .out_right (right_s)
    );

    assign gate      = ctrl_q[CTL_EN] && (ctrl_q[CTL_SLOT3] || ctrl_q[CTL_SLOT4]);
    assign snk_valid = gate && ((int'(level) >= HALF) ||
                                (burst_q && int'(level) >= 2));
    assign pop       = snk_valid && snk_ready;
    assign snk_data  = {left_s, right_s};

    // Burst tracker: keeps draining below half once a pair has moved.
    always_ff @(posedge clk) begin
        if (!rst_n || main_flush || !gate) burst_q <= 1'b0;
        else if (pop)                     burst_q <= 1'b1;
        else if (int'(level) < 2)         burst_q <= 1'b0;
    end

    // Level after this cycle's push and pop, for the flag rules.
    always_comb begin
        level_n = level;
        if (push_ok) level_n = level_n + (push_two ? LW'(2) : LW'(1));
        if (pop)     level_n = level_n - LW'(2);
    end

    atx_status #(.DEPTH(DEPTH)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (main_flush),
        .push_ok (push_ok),
        .pop     (pop),
        .iclr_ur (iclr_ur),
        .level_n (level_n),
        .busy    (snk_valid),
        .ie      (ie_q),
        .flags   (flags),
        .ris     (ris),
        .irq     (irq)
    );

    // Register read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            A_CTRL: reg_rdata[15:0] = ctrl_q;
            A_STAT: begin
                reg_rdata[0]       = flags.empty;
                reg_rdata[1]       = flags.half_empty;
                reg_rdata[2]       = flags.full;
                reg_rdata[3]       = flags.underrun;
                reg_rdata[4]       = snk_valid;
                reg_rdata[16 +: LW] = level;
            end
            A_RIS:  reg_rdata[6:0] = ris;
            A_IE:   reg_rdata[6:0] = ie_q;
            A_MAIN: reg_rdata[0]   = main_q;
            A_ID:   reg_rdata[2:0] = DEPTH_CODE;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/atx_checker.sv
// Checker: temporal properties on the FIFO level, flags and sink
// handshake. Attached to every audio_tx_fifo instance through bind.
module atx_checker #(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [LW-1:0] level,
    input logic          push_ok,
    input logic          data_wr,
    input logic          cmp_eff,
    input logic          pop,
    input logic          main_flush,
    input logic          full_f,
    input logic          empty_f,
    input logic          snk_valid,
    input logic          snk_ready
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    p_cmp_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && cmp_eff && int'(level) + 2 >= DEPTH && !pop && !main_flush)
        |=> level == $past(level));

    p_full_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        full_f |-> int'(level) == DEPTH);

    p_hold_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready && !reg_wr) |=> snk_valid);

    p_pop_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_ok && !main_flush) |=> level == $past(level) - LW'(2));

    p_empty_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_f |-> level == '0);

endmodule

bind audio_tx_fifo atx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .level      (level),
    .push_ok    (push_ok),
    .data_wr    (data_wr),
    .cmp_eff    (cmp_eff),
    .pop        (pop),
    .main_flush (main_flush),
    .full_f     (flags.full),
    .empty_f    (flags.empty),
    .snk_valid  (snk_valid),
    .snk_ready  (snk_ready)
);

// File: tb/test_audio_tx_fifo.sv
// Bench: table of packing vectors, then directed flag, drain and
// interrupt tests. Inputs change on the falling edge, outputs are read there.
module test_audio_tx_fifo;

    localparam int DEPTH = 8;
    localparam logic [2:0] A_CTRL = 3'd0, A_DATA = 3'd1, A_STAT = 3'd2,
                           A_RIS = 3'd3, A_IE = 3'd4, A_ICLR = 3'd5,
                           A_MAIN = 3'd6, A_ID = 3'd7;

    // ctrl[120:105] w0[104:73] w1[72:41] compact[40] left[39:20] right[19:0]
    localparam int NV = 7;
    localparam logic [120:0] VEC [NV] = '{
        {16'h0009, 32'h0000ABCD, 32'h00001234, 1'b0, 20'hABCD0, 20'h12340},
        {16'h2009, 32'h0003FFFF, 32'h00012345, 1'b0, 20'hFFFFC, 20'h48D14},
        {16'h4009, 32'hFFF12345, 32'h000ABCDE, 1'b0, 20'h12345, 20'hABCDE},
        {16'h6009, 32'h00000ABC, 32'hFFFFF123, 1'b0, 20'hABC00, 20'h12300},
        {16'h8009, 32'h56781234, 32'h00000000, 1'b1, 20'h12340, 20'h56780},
        {16'hE009, 32'h0FED0321, 32'h00000000, 1'b1, 20'h32100, 20'hFED00},
        {16'hC009, 32'h00054321, 32'h000FEDCB, 1'b0, 20'h54321, 20'hFEDCB}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        snk_valid;
    logic        snk_ready;
    logic [39:0] snk_data;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    audio_tx_fifo #(.DEPTH(DEPTH)) i_audio_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .snk_valid (snk_valid),
        .snk_ready (snk_ready),
        .snk_data  (snk_data),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic flush();
        wr(A_MAIN, 32'h0);
        wr(A_MAIN, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; snk_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state; R11 identification code for depth 8
        rd(A_STAT, v); check("R12 status", v, 32'h3);
        rd(A_RIS, v);  check("R12 raw irq", v, 32'h05);
        rd(A_CTRL, v); check("R12 ctrl", v, 32'h0);
        check("R12 irq", irq, 1'b0);
        check("R12 valid", snk_valid, 1'b0);
        rd(A_ID, v);   check("R11 depth code", v, 32'h0);

        // R1 R2 R3 R4 R6: packing table, pair offered at half full, sink stalled
        for (int i = 0; i < NV; i++) begin
            flush();
            wr(A_CTRL, {16'h0, VEC[i][120:105]});
            wr(A_DATA, VEC[i][104:73]);
            wr(A_DATA, VEC[i][72:41]);
            if (!VEC[i][40]) begin
                wr(A_DATA, VEC[i][104:73]);
                wr(A_DATA, VEC[i][72:41]);
            end
            check("R6 valid at half", snk_valid, 1'b1);
            check("R3/R4 pair data", snk_data, VEC[i][39:0]);
            rd(A_STAT, v); check("R2 level", v[27:16], 12'd4);
            rd(A_CTRL, v); check("R1 ctrl readback", v, {16'h0, VEC[i][120:105]});
        end

        // R3 R5: overfill in non-compact mode, ninth write dropped
        flush();
        wr(A_CTRL, 32'h0000);
        for (int i = 0; i < 9; i++) wr(A_DATA, 32'(i));
        rd(A_STAT, v); check("R5 full status", v, 32'h0008_0004);
        rd(A_RIS, v);  check("R8 raw irq full", v, 32'h0);

        // R6 R7: enable with ready high, drains all pairs incl. below half
        snk_ready = 1'b1;
        wr(A_CTRL, 32'h0009);
        repeat (10) @(negedge clk);
        rd(A_STAT, v); check("R7 drained status", v, 32'h0000_000B);
        rd(A_RIS, v);  check("R8 raw irq underrun", v, 32'h25);

        // R9: clear register without bit 5 leaves underrun, bit 5 clears it
        wr(A_ICLR, 32'h0000_0001);
        rd(A_STAT, v); check("R9 other bit ignored", v, 32'h0000_000B);
        wr(A_ICLR, 32'h0000_0020);
        rd(A_STAT, v); check("R9 underrun cleared", v, 32'h3);
        rd(A_RIS, v);  check("R9 raw irq", v, 32'h05);

        // R8: mask selects which raw bits reach irq
        wr(A_IE, 32'h20); check("R8 irq masked ur", irq, 1'b0);
        rd(A_IE, v);      check("R1 ie readback", v, 32'h20);
        wr(A_IE, 32'h01); check("R8 irq complete", irq, 1'b1);
        wr(A_IE, 32'h04); check("R8 irq half", irq, 1'b1);
        wr(A_IE, 32'h00); check("R8 irq off", irq, 1'b0);

        // R4: compact threshold, level+2 must stay below depth
        snk_ready = 1'b0;
        flush();
        wr(A_CTRL, 32'h8000);
        wr(A_DATA, 32'h1); wr(A_DATA, 32'h2); wr(A_DATA, 32'h3);
        rd(A_STAT, v); check("R4 three compact writes", v, 32'h0006_0000);
        wr(A_DATA, 32'h4);
        rd(A_STAT, v); check("R4 fourth write dropped", v, 32'h0006_0000);

        // R6: enabled but slots 3 and 4 off, nothing is offered
        snk_ready = 1'b1;
        wr(A_CTRL, 32'h8003);
        repeat (4) @(negedge clk);
        check("R6 no slot no valid", snk_valid, 1'b0);
        rd(A_STAT, v); check("R6 level kept", v[27:16], 12'd6);
        wr(A_CTRL, 32'h8011);
        repeat (8) @(negedge clk);
        rd(A_STAT, v); check("R6 slot4 drains", v, 32'h0000_000B);

        // R7: a single pop from 6 to 4 sets half-empty, clears nothing else
        snk_ready = 1'b0;
        flush();
        wr(A_CTRL, 32'h0000);
        for (int i = 0; i < 6; i++) wr(A_DATA, 32'h10 + 32'(i));
        rd(A_STAT, v); check("R5 half-empty cleared", v, 32'h0006_0000);
        wr(A_CTRL, 32'h0009);
        check("R6 pair order", snk_data, {20'h00100, 20'h00110});
        @(negedge clk); snk_ready = 1'b1;
        @(negedge clk); snk_ready = 1'b0;
        rd(A_STAT, v); check("R7 one pop", v, 32'h0004_0012);
        rd(A_RIS, v);  check("R8 raw irq busy", v, 32'h04);
        check("R6 next pair", snk_data, {20'h00120, 20'h00130});

        // R10: main control clear empties the FIFO
        wr(A_MAIN, 32'h0);
        rd(A_STAT, v); check("R10 flush status", v, 32'h3);
        check("R10 valid low", snk_valid, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule